// File: doc/BRIEF.md
# Clock Synchronizer Status Event Register

This block watches the four level status signals of a clock synchronizer: primary reference lost, secondary reference lost, PLL in holdover and PLL unlocked. Each signal passes through a synchronizer. Every change of level, in either direction, then sets a sticky bit of its own in an event register. An interrupt line stays high as long as any event bit is set.

A host reads three byte-wide registers over a small registered read port:

- **Status byte.** Shows the present synchronized levels of the four signals.
- **Event register.** Returns the pending transitions and clears them in the same access.
- **Configuration byte.** Reports the interrupt line number assigned to the function.

The read port is meant for a chip-level bus decoder. That decoder turns one register window into `rd_en`/`rd_addr` strobes.

Top module: `clkevt_top`

## Requirements
- R1: A read at address 0 returns the status byte. Bit 7 is the synchronized primary-lost level, bit 6 secondary-lost, bit 5 holdover and bit 4 unlock. Bits 3..0 read as zero.
- R2: Source k is numbered 0 for primary-lost, 1 for secondary-lost, 2 for holdover and 3 for unlock. A 0→1 change of source k sets event bit 2k, and a 1→0 change sets event bit 2k+1.
- R3: An event bit, once set, stays set until the event register is read. Several changes of the same or other sources accumulate.
- R4: A read at address 1 returns the event bits pending before the read on `rd_data` one cycle later and clears them. Reads at other addresses leave the event bits unchanged.
- R5: If an edge sets a bit on the same clock edge as a clearing read, the read returns the older bits and the new bit stays pending.
- R6: `irq` is high exactly while at least one event bit is set. It rises on the third rising clock edge after an input change, and falls in the cycle after a clearing read that leaves no bit set.
- R7: A read at address 2 returns the configuration byte, with zeros in bits 7..4 and the parameter IRQ_LINE in bits 3..0. The value 0xF in bits 3..0 marks the function as absent. A read at address 3 returns zero.
- R8: Synchronous reset clears the event bits, `irq`, `rd_data` and the synchronizers. Inputs that are already high when reset is released produce no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stat_lvl | input | NUM_SRC (4) | Asynchronous status levels: [0] primary lost, [1] secondary lost, [2] holdover, [3] unlock |
| rd_en | input | 1 | Read strobe, one cycle per access |
| rd_addr | input | 2 | Register select: 0 status, 1 events, 2 configuration |
| rd_data | output | 2*NUM_SRC (8) | Registered read data, valid the cycle after `rd_en` |
| irq | output | 1 | Level interrupt, high while any event is pending |

## Verification
The hardest case to reach from the ports is a new edge that lands on the same clock edge as a clearing read. The synchronizer and edge detector add three cycles of delay, so the bench changes an input on a falling edge, lets exactly two falling edges pass, and then issues the read, which meets the new bit at the third rising edge.

A second hard case is an input already high when reset is released. The bench holds all inputs high through reset and then checks for silence.

The bench also sweeps every ordered pair of the sixteen input patterns. For each pair it predicts the rising and falling bits arithmetically.

// File: rtl/clkevt_pkg.sv
package clkevt_pkg;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_STATUS = 2'd0,
    ADDR_EVENT  = 2'd1,
    ADDR_CONFIG = 2'd2,
    ADDR_SPARE  = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/clkevt_sync.sv
module clkevt_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= '0;
    else     chain[0] <= din;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[s] <= '0;
      else     chain[s] <= chain[s-1];
    end
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/clkevt_edge.sv
module clkevt_edge #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned SETTLE = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] lvl,
  output logic [WIDTH-1:0] rise,
  output logic [WIDTH-1:0] fall,
  output logic             armed
);
  localparam int unsigned CNT_W = $clog2(SETTLE + 1);

  logic [WIDTH-1:0] prev_q;
  logic [CNT_W-1:0] cnt_q;

  assign armed = (cnt_q == CNT_W'(SETTLE));

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      cnt_q  <= '0;
    end else begin
      prev_q <= lvl;
      if (!armed) cnt_q <= cnt_q + 1'b1;
    end
  end

  always_comb begin
    rise = '0;
    fall = '0;
    if (armed) begin
      rise = lvl & ~prev_q;
      fall = ~lvl & prev_q;
    end
  end
endmodule

// File: rtl/clkevt_store.sv
module clkevt_store #(
  parameter int unsigned SRC = 4,
  localparam int unsigned EVT_W = 2 * SRC
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SRC-1:0]   rise,
  input  logic [SRC-1:0]   fall,
  input  logic             clr,
  output logic [EVT_W-1:0] evt_q,
  output logic             irq
);
  logic [EVT_W-1:0] set_v;
  logic [EVT_W-1:0] evt_d;

  for (genvar k = 0; k < SRC; k++) begin : g_map
    assign set_v[2*k]   = rise[k];
    assign set_v[2*k+1] = fall[k];
  end

  assign evt_d = (clr ? '0 : evt_q) | set_v;

  always_ff @(posedge clk) begin
    if (rst) begin
      evt_q <= '0;
      irq   <= 1'b0;
    end else begin
      evt_q <= evt_d;
      irq   <= |evt_d;
    end
  end
endmodule

// File: rtl/clkevt_top.sv
module clkevt_top #(
  parameter int unsigned NUM_SRC     = 4,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned IRQ_W       = 4,
  parameter logic [IRQ_W-1:0] IRQ_LINE = 4'd5,
  localparam int unsigned DATA_W = 2 * NUM_SRC
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_SRC-1:0]  stat_lvl,
  input  logic                rd_en,
  input  logic [1:0]          rd_addr,
  output logic [DATA_W-1:0]   rd_data,
  output logic                irq
);
  import clkevt_pkg::*;

  logic [NUM_SRC-1:0] lvl_s;
  logic [NUM_SRC-1:0] rise;
  logic [NUM_SRC-1:0] fall;
  logic               armed;
  logic [DATA_W-1:0]  evt_q;
  logic               rd_clr;
  logic [DATA_W-1:0]  status_byte;
  logic [DATA_W-1:0]  config_byte;
  logic [DATA_W-1:0]  rd_mux;

  clkevt_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(stat_lvl), .dout(lvl_s)
  );

  clkevt_edge #(.WIDTH(NUM_SRC), .SETTLE(SYNC_STAGES + 1)) u_edge (
    .clk(clk), .rst(rst), .lvl(lvl_s), .rise(rise), .fall(fall), .armed(armed)
  );

  assign rd_clr = rd_en && (rd_addr == ADDR_EVENT);

  clkevt_store #(.SRC(NUM_SRC)) u_store (
    .clk(clk), .rst(rst), .rise(rise), .fall(fall), .clr(rd_clr),
    .evt_q(evt_q), .irq(irq)
  );

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_status
    assign status_byte[DATA_W-1-k] = lvl_s[k];
  end
  assign status_byte[DATA_W-NUM_SRC-1:0] = '0;

  assign config_byte = DATA_W'(IRQ_LINE);

  always_comb begin
    unique case (rd_addr)
      ADDR_STATUS: rd_mux = status_byte;
      ADDR_EVENT:  rd_mux = evt_q;
      ADDR_CONFIG: rd_mux = config_byte;
      default:     rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rd_mux;
  end
endmodule

// File: rtl/clkevt_chk.sv
module clkevt_chk #(
  parameter int unsigned NUM_SRC = 4,
  parameter int unsigned IRQ_W   = 4,
  parameter logic [IRQ_W-1:0] IRQ_LINE = 4'd5,
  localparam int unsigned DATA_W = 2 * NUM_SRC
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_en,
  input logic [1:0]        rd_addr,
  input logic [DATA_W-1:0] rd_data,
  input logic              irq,
  input logic [DATA_W-1:0] evt_q,
  input logic              armed
);
  import clkevt_pkg::*;

  // R4
  evt_read_returns_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_addr == ADDR_EVENT) |=> (rd_data == $past(evt_q)));

  // R3
  sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(rd_en && rd_addr == ADDR_EVENT) |=> ((evt_q & $past(evt_q)) == $past(evt_q)));

  // R6
  irq_tracks_events_chk: assert property (@(posedge clk) disable iff (rst)
    irq == (evt_q != '0));

  // R8
  quiet_until_armed_chk: assert property (@(posedge clk) disable iff (rst)
    (!armed && evt_q == '0) |=> (evt_q == '0));

  // R7
  config_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_addr == ADDR_CONFIG) |=> (rd_data == DATA_W'(IRQ_LINE)));

  // R1
  status_low_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_addr == ADDR_STATUS) |=> (rd_data[DATA_W-NUM_SRC-1:0] == '0));
endmodule

bind clkevt_top clkevt_chk #(.NUM_SRC(NUM_SRC), .IRQ_W(IRQ_W), .IRQ_LINE(IRQ_LINE)) u_chk (
  .clk(clk), .rst(rst), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
  .irq(irq), .evt_q(evt_q), .armed(armed)
);

// File: tb/test_clkevt_top.sv
`timescale 1ns/1ps
module test_clkevt_top;
  localparam logic [3:0] IRQ_NUM = 4'd9;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] stat_lvl = '0;
  logic       rd_en = 1'b0;
  logic [1:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       irq;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  clkevt_top #(.IRQ_LINE(IRQ_NUM)) i_clkevt_top (
    .clk(clk), .rst(rst), .stat_lvl(stat_lvl), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    v = rd_data;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] edges(input logic [3:0] p, input logic [3:0] n);
    logic [7:0] e = '0;
    for (int k = 0; k < 4; k++) begin
      if (!p[k] && n[k]) e[2*k]   = 1'b1;
      if (p[k] && !n[k]) e[2*k+1] = 1'b1;
    end
    return e;
  endfunction

  function automatic logic [7:0] status_of(input logic [3:0] n);
    logic [7:0] s = '0;
    for (int k = 0; k < 4; k++) s[7-k] = n[k];
    return s;
  endfunction

  task automatic do_reset(input logic [3:0] lv);
    @(negedge clk);
    stat_lvl = lv; rst = 1'b1;
    idle(4);
    rst = 1'b0;
  endtask

  initial begin
    logic [7:0] v;
    // R8: reset with quiet inputs
    do_reset(4'h0);
    chk("R8 rd_data after reset", rd_data, 8'h00);
    chk("R8 irq after reset", {7'd0, irq}, 8'h00);
    idle(8);
    rd(2'd1, v); chk("R8 events after reset", v, 8'h00);
    rd(2'd0, v); chk("R1 status after reset", v, 8'h00);
    // R7: configuration byte and spare address
    rd(2'd2, v); chk("R7 config byte", v, {4'h0, IRQ_NUM});
    rd(2'd3, v); chk("R7 spare address", v, 8'h00);

    // R8: inputs high through reset give no event
    do_reset(4'hF);
    idle(10);
    chk("R8 irq with high inputs", {7'd0, irq}, 8'h00);
    rd(2'd1, v); chk("R8 no spurious events", v, 8'h00);
    rd(2'd0, v); chk("R1 status all high", v, 8'hF0);
    do_reset(4'h0);
    idle(8);

    // R6: exact latency of irq
    @(negedge clk); stat_lvl = 4'b0100;
    @(negedge clk); @(negedge clk);
    chk("R6 irq low before third edge", {7'd0, irq}, 8'h00);
    @(negedge clk);
    chk("R6 irq high at third edge", {7'd0, irq}, 8'h01);
    // R4: other reads do not clear
    rd(2'd0, v); chk("R1 status holdover", v, 8'h20);
    rd(2'd2, v); chk("R4 config read keeps events", {7'd0, irq}, 8'h01);
    rd(2'd1, v); chk("R4 event read value", v, 8'h10);
    chk("R6 irq low after clearing read", {7'd0, irq}, 8'h00);
    rd(2'd1, v); chk("R4 event register cleared", v, 8'h00);

    // R3: accumulation of both directions
    @(negedge clk); stat_lvl = 4'b0101;
    idle(6);
    @(negedge clk); stat_lvl = 4'b0100;
    idle(6);
    @(negedge clk); stat_lvl = 4'b1100;
    idle(6);
    rd(2'd1, v); chk("R3 accumulated events", v, 8'h43);

    // R5: new edge on the same edge as a clearing read
    @(negedge clk); stat_lvl = 4'b1110;
    idle(6);
    @(negedge clk); stat_lvl = 4'b1111;
    @(negedge clk); @(negedge clk);
    rd_en = 1'b1; rd_addr = 2'd1;
    @(negedge clk);
    rd_en = 1'b0;
    chk("R5 read returns older bits", rd_data, 8'h04);
    chk("R5 irq stays high", {7'd0, irq}, 8'h01);
    rd(2'd1, v); chk("R5 new bit kept", v, 8'h01);

    // R2 R1 R6: sweep all ordered pairs of patterns
    for (int p = 0; p < 16; p++) begin
      for (int n = 0; n < 16; n++) begin
        logic [7:0] e;
        @(negedge clk); stat_lvl = 4'(p);
        idle(6);
        rd(2'd1, v);
        @(negedge clk); stat_lvl = 4'(n);
        idle(6);
        e = edges(4'(p), 4'(n));
        chk("R6 irq in sweep", {7'd0, irq}, {7'd0, e != 8'h00});
        rd(2'd1, v); chk("R2 sweep events", v, e);
        chk("R6 irq cleared in sweep", {7'd0, irq}, 8'h00);
        rd(2'd0, v); chk("R1 sweep status", v, status_of(4'(n)));
      end
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule